// File: doc/BRIEF.md
# Page-Mode DRAM Controller

This block sits between a synchronous host and a 16-bit asynchronous DRAM whose row and column addresses share one set of pins. The host offers one request at a time on a valid/ready handshake. Each request carries a 20-bit word address, a read/write flag, two byte-lane enables and write data. The controller splits the address into a 12-bit row and an 8-bit column. It opens the row by driving it onto the address pins and pulling RAS low. It then drives the column and pulls the column strobes of the enabled lanes low.

After an access the row stays open. A later request to the same row is a page hit and is served with a column cycle only, without a new RAS cycle. A request to another row closes the row, waits out the RAS precharge and opens the new row. An outside arbiter can close the row through `close_req`, for example to make room for refresh. The controller also closes the row by itself before RAS has been low for `T_RASP_MAX` cycles.

Every timing limit is a parameter counted in clock cycles, so one design serves any clock period. Writes are always early writes. WE is low and the data bus is driven before the first strobe falls, so the DRAM never drives its data pins during a write. Read data is captured one clock after the access time `T_ACC` has passed since the strobe fell. It is returned with a one-cycle `rd_valid` pulse.

The state machine has these states:
- `ST_IDLE`: row closed, precharged.
- `ST_ROW_SETUP`: row address on the pins, RAS still high, 1 cycle.
- `ST_ROW_HOLD`: RAS low, row address held, `T_RAH` cycles.
- `ST_COL_SETUP`: column address driven, with WE and data for writes, `T_COL` cycles.
- `ST_STROBE`: column strobes low. This lasts `T_CAS` cycles for a write and max(`T_CAS`, `T_ACC`+1) cycles for a read.
- `ST_CAS_PRE`: strobes high, `T_CP` cycles.
- `ST_OPEN`: row open, waiting.
- `ST_CLOSE`: RAS high, `T_RP` cycles.

The transitions are:
- IDLE→ROW_SETUP on an accepted request.
- ROW_SETUP→ROW_HOLD→COL_SETUP→STROBE→CAS_PRE→OPEN, each when its timer expires.
- OPEN→COL_SETUP on an accepted hit.
- OPEN→CLOSE on an accepted miss, on `close_req`, or when the RAS-low guard trips.
- CLOSE→ROW_SETUP when a miss is pending, otherwise CLOSE→IDLE.

Top module: `fpm_dram_ctrl`

## Requirements
- R1: While reset is asserted and right after it, `dram_ras_n`, `dram_ucas_n`, `dram_lcas_n`, `dram_we_n` and `dram_oe_n` are high, `dram_dq_oe` and `rd_valid` are low, and `req_ready` is high.
- R2: When RAS falls, `dram_addr` carries the row (address bits 19:8). When a column strobe falls, `dram_addr[7:0]` carries the column (address bits 7:0) and the upper four bits are zero. A column strobe is only ever low while RAS is low.
- R3: `dram_lcas_n` serves byte lane 7:0 (`req_be[0]`) and `dram_ucas_n` serves lane 15:8 (`req_be[1]`). Only the strobes of enabled lanes fall, and when both lanes are enabled the two strobes fall and rise in the same cycle.
- R4: In a write, WE is low and `dram_dq_oe` is high with the write data on `dram_dq_out` at least one cycle before the strobe falls, and both stay so while the strobe is low. `dram_oe_n` stays high whenever `dram_dq_oe` is high.
- R5: In a read, `dram_oe_n` is low while the strobes are low. Data is captured from `dram_dq_in` at the end of strobe-low cycle `T_ACC`+1 and appears on `rd_data` with a single-cycle `rd_valid` pulse.
- R6: A request whose row equals the open row is served with no new RAS falling edge.
- R7: A request to another row makes RAS rise. RAS then stays high at least `T_RP` cycles before it falls again for the new row.
- R8: Strobe-low pulses last at least `T_CAS` cycles. Between two strobe pulses within one row, both strobes are high for at least `T_CP` cycles.
- R9: With `close_req` high and a row open, `req_ready` is low and RAS rises. The next request, even to the previous row, opens the row again.
- R10: RAS never stays low for `T_RASP_MAX` cycles or more, even under an unbroken stream of page hits. The row is closed and reopened as needed.
- R11: Each RAS-low period lasts at least `T_RAS_MIN` cycles.
- R12: Exactly one request is taken per cycle where `req_valid` and `req_ready` are both high. `req_ready` is low in every state except `ST_IDLE` and an admissible `ST_OPEN`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller takes the request this cycle |
| req_addr | input | 20 | Word address, row in 19:8, column in 7:0 |
| req_write | input | 1 | 1 = write, 0 = read |
| req_be | input | 2 | Byte-lane enables, bit 1 upper lane, bit 0 lower lane |
| req_wdata | input | 16 | Write data |
| rd_valid | output | 1 | One-cycle pulse with read data |
| rd_data | output | 16 | Read data |
| close_req | input | 1 | Close the open row (from an outside arbiter) |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_ucas_n | output | 1 | Upper-lane column strobe, active low |
| dram_lcas_n | output | 1 | Lower-lane column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_addr | output | 12 | Multiplexed row/column address |
| dram_dq_out | output | 16 | Data toward the DRAM |
| dram_dq_oe | output | 1 | Drive enable for `dram_dq_out` |
| dram_dq_in | input | 16 | Data from the DRAM |

## Verification
On every cycle the assertions check the following:
- no strobe is low outside a RAS-low period;
- the two lane strobes move together;
- WE and the data drive lead the strobe in writes, and OE is never low while the bus is driven;
- the minimum RAS precharge, the minimum and maximum RAS-low time, the strobe width and the strobe precharge all hold;
- `rd_valid` is a single-cycle pulse.

Only the bench's scenarios can show the rest. These are that the right row and column reach the pins, that data written through chosen lanes reads back correctly, and that data is not captured before the access time. They also cover the choice between a hit and a reopen, and that a close request or a long hit stream really leads to a fresh row activation.

// File: rtl/fpm_pkg.sv
package fpm_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ROW_SETUP,
        ST_ROW_HOLD,
        ST_COL_SETUP,
        ST_STROBE,
        ST_CAS_PRE,
        ST_OPEN,
        ST_CLOSE
    } fpm_state_e;

    function automatic int fpm_max(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/fpm_timer.sv
// Down-counter: after load with N, done is high in the N-th cycle.
module fpm_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         done
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign done = (cnt_q <= W'(1));
endmodule

// File: rtl/fpm_ras_guard.sv
// Counts cycles of RAS low; flags minimum reached and approach of the maximum.
module fpm_ras_guard #(
    parameter int T_RAS_MIN  = 8,
    parameter int T_RASP_MAX = 20000,
    parameter int GUARD      = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ras_low,
    output logic min_met,
    output logic near_limit
);
    localparam int CW = $clog2(T_RASP_MAX + 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n || !ras_low) begin
            cnt_q <= '0;
        end else if (int'(cnt_q) < T_RASP_MAX) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign min_met    = (int'(cnt_q) >= T_RAS_MIN - 1);
    assign near_limit = (int'(cnt_q) + GUARD >= T_RASP_MAX);
endmodule

// File: rtl/fpm_addr_mux.sv
// Selects row or zero-extended column onto the shared address pins.
module fpm_addr_mux #(
    parameter int ROW_W = 12,
    parameter int COL_W = 8
) (
    input  logic             sel_col,
    input  logic [ROW_W-1:0] row,
    input  logic [COL_W-1:0] col,
    output logic [ROW_W-1:0] pins
);
    generate
        if (COL_W == ROW_W) begin : g_same
            assign pins = sel_col ? col : row;
        end else begin : g_pad
            assign pins = sel_col ? {{(ROW_W-COL_W){1'b0}}, col} : row;
        end
    endgenerate
endmodule

// File: rtl/fpm_dram_ctrl.sv
module fpm_dram_ctrl
    import fpm_pkg::*;
#(
    parameter int ROW_W      = 12,
    parameter int COL_W      = 8,
    parameter int DATA_W     = 16,
    parameter int T_RP       = 10,
    parameter int T_RAH      = 2,
    parameter int T_COL      = 2,
    parameter int T_CAS      = 4,
    parameter int T_ACC      = 10,
    parameter int T_CP       = 2,
    parameter int T_RAS_MIN  = 14,
    parameter int T_RASP_MAX = 20000
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    output logic                    req_ready,
    input  logic [ROW_W+COL_W-1:0]  req_addr,
    input  logic                    req_write,
    input  logic [1:0]              req_be,
    input  logic [DATA_W-1:0]       req_wdata,
    output logic                    rd_valid,
    output logic [DATA_W-1:0]       rd_data,
    input  logic                    close_req,
    output logic                    dram_ras_n,
    output logic                    dram_ucas_n,
    output logic                    dram_lcas_n,
    output logic                    dram_we_n,
    output logic                    dram_oe_n,
    output logic [ROW_W-1:0]        dram_addr,
    output logic [DATA_W-1:0]       dram_dq_out,
    output logic                    dram_dq_oe,
    input  logic [DATA_W-1:0]       dram_dq_in
);
    localparam int ADDR_W     = ROW_W + COL_W;
    localparam int CAS_RD_LEN = fpm_max(T_CAS, T_ACC + 1);
    localparam int MAX_DUR    = fpm_max(fpm_max(fpm_max(T_RP, T_RAH), fpm_max(T_COL, T_CP)),
                                        CAS_RD_LEN);
    localparam int DUR_W      = $clog2(MAX_DUR + 1);
    localparam int GUARD      = T_COL + CAS_RD_LEN + T_CP + 2;

    fpm_state_e state_q, state_d;

    logic [ADDR_W-1:0] addr_q;
    logic              wr_q;
    logic [1:0]        be_q;
    logic [DATA_W-1:0] wdata_q;
    logic              pending_q;

    logic              tmr_load;
    logic [DUR_W-1:0]  tmr_val;
    logic              tmr_done;
    logic              ras_low;
    logic              min_met;
    logic              near_limit;
    logic              accept;
    logic              row_hit;
    logic              open_admit;
    logic              sel_col;

    // ---------------- helpers ----------------
    fpm_timer #(.W(DUR_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .done     (tmr_done)
    );

    fpm_ras_guard #(
        .T_RAS_MIN  (T_RAS_MIN),
        .T_RASP_MAX (T_RASP_MAX),
        .GUARD      (GUARD)
    ) u_guard (
        .clk        (clk),
        .rst_n      (rst_n),
        .ras_low    (ras_low),
        .min_met    (min_met),
        .near_limit (near_limit)
    );

    fpm_addr_mux #(.ROW_W(ROW_W), .COL_W(COL_W)) u_amux (
        .sel_col (sel_col),
        .row     (addr_q[ADDR_W-1:COL_W]),
        .col     (addr_q[COL_W-1:0]),
        .pins    (dram_addr)
    );

    // ---------------- admission ----------------
    assign open_admit = (state_q == ST_OPEN) && !close_req && !near_limit && min_met;
    assign req_ready  = (state_q == ST_IDLE) || open_admit;
    assign accept     = req_valid && req_ready;
    assign row_hit    = (req_addr[ADDR_W-1:COL_W] == addr_q[ADDR_W-1:COL_W]);

    // ---------------- next state ----------------
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:      if (accept) state_d = ST_ROW_SETUP;
            ST_ROW_SETUP: if (tmr_done) state_d = ST_ROW_HOLD;
            ST_ROW_HOLD:  if (tmr_done) state_d = ST_COL_SETUP;
            ST_COL_SETUP: if (tmr_done) state_d = ST_STROBE;
            ST_STROBE:    if (tmr_done) state_d = ST_CAS_PRE;
            ST_CAS_PRE:   if (tmr_done) state_d = ST_OPEN;
            ST_OPEN: begin
                if (accept) begin
                    state_d = row_hit ? ST_COL_SETUP : ST_CLOSE;
                end else if ((close_req || near_limit) && min_met) begin
                    state_d = ST_CLOSE;
                end
            end
            ST_CLOSE:     if (tmr_done) state_d = pending_q ? ST_ROW_SETUP : ST_IDLE;
            default:      state_d = ST_IDLE;
        endcase
    end

    // duration of the state being entered
    assign tmr_load = (state_d != state_q);
    always_comb begin
        tmr_val = DUR_W'(1);
        unique case (state_d)
            ST_ROW_HOLD:  tmr_val = DUR_W'(T_RAH);
            ST_COL_SETUP: tmr_val = DUR_W'(T_COL);
            ST_STROBE:    tmr_val = wr_q ? DUR_W'(T_CAS) : DUR_W'(CAS_RD_LEN);
            ST_CAS_PRE:   tmr_val = DUR_W'(T_CP);
            ST_CLOSE:     tmr_val = DUR_W'(T_RP);
            ST_IDLE, ST_ROW_SETUP, ST_OPEN: tmr_val = DUR_W'(1);
            default:      tmr_val = DUR_W'(1);
        endcase
    end

    // ---------------- state and request registers ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            addr_q    <= '0;
            wr_q      <= 1'b0;
            be_q      <= 2'b00;
            wdata_q   <= '0;
            pending_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                addr_q  <= req_addr;
                wr_q    <= req_write;
                be_q    <= req_be;
                wdata_q <= req_wdata;
            end
            if (accept && state_q == ST_OPEN && !row_hit) begin
                pending_q <= 1'b1;
            end else if (state_q == ST_CLOSE && tmr_done) begin
                pending_q <= 1'b0;
            end
        end
    end

    // ---------------- DRAM pin outputs ----------------
    always_comb begin
        ras_low     = 1'b0;
        sel_col     = 1'b0;
        dram_ucas_n = 1'b1;
        dram_lcas_n = 1'b1;
        dram_we_n   = 1'b1;
        dram_oe_n   = 1'b1;
        dram_dq_oe  = 1'b0;
        unique case (state_q)
            ST_IDLE, ST_ROW_SETUP, ST_CLOSE: begin
                ras_low = 1'b0;
            end
            ST_ROW_HOLD: begin
                ras_low = 1'b1;
            end
            ST_COL_SETUP: begin
                ras_low    = 1'b1;
                sel_col    = 1'b1;
                dram_we_n  = !wr_q;
                dram_dq_oe = wr_q;
            end
            ST_STROBE: begin
                ras_low     = 1'b1;
                sel_col     = 1'b1;
                dram_ucas_n = !be_q[1];
                dram_lcas_n = !be_q[0];
                dram_we_n   = !wr_q;
                dram_oe_n   = wr_q;
                dram_dq_oe  = wr_q;
            end
            ST_CAS_PRE: begin
                ras_low    = 1'b1;
                sel_col    = 1'b1;
                dram_dq_oe = wr_q;
            end
            ST_OPEN: begin
                ras_low = 1'b1;
                sel_col = 1'b1;
            end
            default: begin
                ras_low = 1'b0;
            end
        endcase
    end

    assign dram_ras_n  = !ras_low;
    assign dram_dq_out = wdata_q;

    // ---------------- read capture ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= (state_q == ST_STROBE) && tmr_done && !wr_q;
            if ((state_q == ST_STROBE) && tmr_done && !wr_q) begin
                rd_data <= dram_dq_in;
            end
        end
    end
endmodule

// File: rtl/fpm_dram_ctrl_chk.sv
module fpm_dram_ctrl_chk #(
    parameter int T_RP       = 10,
    parameter int T_CAS      = 4,
    parameter int T_CP       = 2,
    parameter int T_RAS_MIN  = 14,
    parameter int T_RASP_MAX = 20000
) (
    input logic clk,
    input logic rst_n,
    input logic dram_ras_n,
    input logic dram_ucas_n,
    input logic dram_lcas_n,
    input logic dram_we_n,
    input logic dram_oe_n,
    input logic dram_dq_oe,
    input logic rd_valid,
    input logic req_ready
);
    localparam int CW = $clog2(T_RASP_MAX + T_RP + T_CP + T_CAS + 2);

    logic          cas_act;
    logic [CW-1:0] ras_lo_cnt, ras_hi_cnt, cas_hi_cnt, cas_lo_cnt;

    assign cas_act = !(dram_ucas_n && dram_lcas_n);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ras_lo_cnt <= '0;
            ras_hi_cnt <= CW'(T_RP);
            cas_hi_cnt <= CW'(T_CP);
            cas_lo_cnt <= '0;
        end else begin
            if (!dram_ras_n) begin
                if (ras_lo_cnt != '1) ras_lo_cnt <= ras_lo_cnt + 1'b1;
                ras_hi_cnt <= '0;
            end else begin
                ras_lo_cnt <= '0;
                if (ras_hi_cnt != '1) ras_hi_cnt <= ras_hi_cnt + 1'b1;
            end
            if (dram_ras_n) begin
                cas_hi_cnt <= CW'(T_CP);
            end else if (cas_act) begin
                cas_hi_cnt <= '0;
            end else if (cas_hi_cnt != '1) begin
                cas_hi_cnt <= cas_hi_cnt + 1'b1;
            end
            if (cas_act) begin
                if (cas_lo_cnt != '1) cas_lo_cnt <= cas_lo_cnt + 1'b1;
            end else begin
                cas_lo_cnt <= '0;
            end
        end
    end

    p_cas_inside_ras_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cas_act |-> !dram_ras_n);

    p_lanes_together_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!dram_ucas_n && !dram_lcas_n) |-> ($fell(dram_ucas_n) == $fell(dram_lcas_n)));

    p_lanes_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(dram_ucas_n) && $past(!dram_lcas_n)) |-> $rose(dram_lcas_n));

    p_early_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(cas_act) && !dram_we_n) |-> ($past(!dram_we_n) && $past(dram_dq_oe)));

    p_no_oe_while_driving_r4: assert property (@(posedge clk) disable iff (!rst_n)
        dram_dq_oe |-> dram_oe_n);

    p_rd_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);

    p_ras_precharge_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dram_ras_n) |-> (int'(ras_hi_cnt) >= T_RP));

    p_cas_precharge_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cas_act) |-> (int'(cas_hi_cnt) >= T_CP));

    p_cas_width_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cas_act) |-> (int'(cas_lo_cnt) >= T_CAS));

    p_ras_max_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dram_ras_n) |-> (int'(ras_lo_cnt) < T_RASP_MAX));

    p_ras_min_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dram_ras_n) |-> (int'(ras_lo_cnt) >= T_RAS_MIN));

    p_ready_not_strobing_r12: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !cas_act);
endmodule

bind fpm_dram_ctrl fpm_dram_ctrl_chk #(
    .T_RP       (T_RP),
    .T_CAS      (T_CAS),
    .T_CP       (T_CP),
    .T_RAS_MIN  (T_RAS_MIN),
    .T_RASP_MAX (T_RASP_MAX)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .dram_ras_n  (dram_ras_n),
    .dram_ucas_n (dram_ucas_n),
    .dram_lcas_n (dram_lcas_n),
    .dram_we_n   (dram_we_n),
    .dram_oe_n   (dram_oe_n),
    .dram_dq_oe  (dram_dq_oe),
    .rd_valid    (rd_valid),
    .req_ready   (req_ready)
);

// File: tb/fpm_dram_ctrl_tb.sv
`timescale 1ns/1ps
module fpm_dram_ctrl_tb;
    localparam int T_RP = 4, T_RAH = 2, T_COL = 2, T_CAS = 3, T_ACC = 5, T_CP = 2;
    localparam int T_RAS_MIN = 8, T_RASP_MAX = 200;

    typedef struct packed {
        logic        wr;
        logic        act;
        logic [1:0]  be;
        logic [19:0] addr;
        logic [15:0] data;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 1'b1, 2'b11, 20'h12345, 16'hA5A5},
        '{1'b1, 1'b0, 2'b11, 20'h12346, 16'h1234},
        '{1'b0, 1'b0, 2'b11, 20'h12345, 16'hA5A5},
        '{1'b1, 1'b0, 2'b01, 20'h12346, 16'h00FF},
        '{1'b0, 1'b0, 2'b11, 20'h12346, 16'h12FF},
        '{1'b1, 1'b1, 2'b11, 20'h45600, 16'hBEEF},
        '{1'b1, 1'b0, 2'b10, 20'h45600, 16'h7700},
        '{1'b0, 1'b1, 2'b11, 20'h12345, 16'hA5A5},
        '{1'b0, 1'b1, 2'b11, 20'h45600, 16'h77EF},
        '{1'b0, 1'b0, 2'b01, 20'h45600, 16'h00EF},
        '{1'b1, 1'b1, 2'b11, 20'hFFFFF, 16'h0F0F},
        '{1'b1, 1'b1, 2'b11, 20'h00000, 16'hC3C3},
        '{1'b0, 1'b1, 2'b11, 20'hFFFFF, 16'h0F0F},
        '{1'b0, 1'b1, 2'b11, 20'h00000, 16'hC3C3}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [19:0] req_addr = '0;
    logic        req_write = 1'b0;
    logic [1:0]  req_be = 2'b00;
    logic [15:0] req_wdata = '0;
    logic        rd_valid;
    logic [15:0] rd_data;
    logic        close_req = 1'b0;
    logic        dram_ras_n, dram_ucas_n, dram_lcas_n, dram_we_n, dram_oe_n, dram_dq_oe;
    logic [11:0] dram_addr;
    logic [15:0] dram_dq_out;
    logic [15:0] dram_dq_in = 16'hBAD0;

    int checks = 0;
    int errors = 0;
    int act_cnt = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    fpm_dram_ctrl #(
        .T_RP(T_RP), .T_RAH(T_RAH), .T_COL(T_COL), .T_CAS(T_CAS), .T_ACC(T_ACC),
        .T_CP(T_CP), .T_RAS_MIN(T_RAS_MIN), .T_RASP_MAX(T_RASP_MAX)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_write(req_write), .req_be(req_be), .req_wdata(req_wdata),
        .rd_valid(rd_valid), .rd_data(rd_data), .close_req(close_req),
        .dram_ras_n(dram_ras_n), .dram_ucas_n(dram_ucas_n), .dram_lcas_n(dram_lcas_n),
        .dram_we_n(dram_we_n), .dram_oe_n(dram_oe_n), .dram_addr(dram_addr),
        .dram_dq_out(dram_dq_out), .dram_dq_oe(dram_dq_oe), .dram_dq_in(dram_dq_in)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h (t=%0t)", req, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // ---------------- DRAM model and timing monitor ----------------
    logic [15:0] mem [int];
    logic [19:0] cur_addr = '0;
    logic        cur_wr = 1'b0;
    logic [1:0]  cur_be = 2'b00;
    logic [11:0] m_row = '0;
    bit   p_ras = 1, p_cas = 0, p_we_low = 0, p_dq_oe = 0;
    int   ras_hi = 1000, ras_lo = 0, cas_lo = 0, cas_hi = 0;
    bit   first_in_row = 1;

    always @(negedge clk) begin
        bit cas_now;
        logic [15:0] word;
        int key;
        if (rst_n) begin
            cas_now = !(dram_ucas_n && dram_lcas_n);
            if (p_ras && !dram_ras_n) begin
                chk(ras_hi >= T_RP, "R7 precharge", ras_hi, T_RP);
                act_cnt++;
                m_row = dram_addr;
                first_in_row = 1;
                ras_lo = 0;
            end
            if (!p_ras && dram_ras_n) begin
                chk(ras_lo >= T_RAS_MIN, "R11 ras min", ras_lo, T_RAS_MIN);
                chk(ras_lo < T_RASP_MAX, "R10 ras max", ras_lo, T_RASP_MAX);
                ras_hi = 0;
            end
            if (cas_now && !p_cas) begin
                key = int'({m_row, dram_addr[7:0]});
                chk({m_row, dram_addr[7:0]} == cur_addr && dram_addr[11:8] == 4'h0,
                    "R2 address", int'({m_row, dram_addr[7:0]}), int'(cur_addr));
                chk({!dram_ucas_n, !dram_lcas_n} == cur_be, "R3 lane strobes",
                    int'({!dram_ucas_n, !dram_lcas_n}), int'(cur_be));
                if (!first_in_row)
                    chk(cas_hi >= T_CP, "R8 cas precharge", cas_hi, T_CP);
                if (cur_wr) begin
                    chk(p_we_low && p_dq_oe && !dram_we_n && dram_oe_n, "R4 early write",
                        int'({p_we_low, p_dq_oe}), 3);
                    word = mem.exists(key) ? mem[key] : 16'h0000;
                    if (!dram_ucas_n) word[15:8] = dram_dq_out[15:8];
                    if (!dram_lcas_n) word[7:0] = dram_dq_out[7:0];
                    mem[key] = word;
                end
                first_in_row = 0;
                cas_lo = 0;
            end
            if (!cas_now && p_cas) begin
                chk(cas_lo >= T_CAS, "R8 cas width", cas_lo, T_CAS);
                cas_hi = 0;
            end
            if (cas_now && cur_wr)
                chk(!dram_we_n && dram_dq_oe, "R4 write held", int'({dram_we_n, dram_dq_oe}), 1);
            if (dram_ras_n) ras_hi++; else ras_lo++;
            if (cas_now) cas_lo++; else cas_hi++;
            // read data becomes valid after T_ACC full strobe-low cycles
            if (cas_now && !dram_oe_n && cas_lo >= T_ACC + 1) begin
                key = int'({m_row, dram_addr[7:0]});
                word = mem.exists(key) ? mem[key] : 16'h0000;
                dram_dq_in <= {dram_ucas_n ? 8'h00 : word[15:8], dram_lcas_n ? 8'h00 : word[7:0]};
            end else begin
                dram_dq_in <= 16'hBAD0;
            end
            p_ras = dram_ras_n;
            p_cas = cas_now;
            p_we_low = !dram_we_n;
            p_dq_oe = dram_dq_oe;
        end
    end

    // watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d expected < 150000 cycles", cycles);
            finish_run();
        end
    end

    // ---------------- host side ----------------
    task automatic issue(input bit wr, input logic [19:0] a, input logic [1:0] be,
                         input logic [15:0] d, output logic [15:0] rdat);
        int wait_cnt;
        @(negedge clk);
        cur_addr = a; cur_wr = wr; cur_be = be;
        req_valid = 1'b1; req_addr = a; req_write = wr; req_be = be; req_wdata = d;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        chk(req_ready == 1'b0, "R12 ready low while busy", int'(req_ready), 0);
        rdat = 16'h0;
        if (!wr) begin
            wait_cnt = 0;
            while (!rd_valid && wait_cnt < 100) begin
                @(negedge clk);
                wait_cnt++;
            end
            rdat = rd_data;
            @(negedge clk);
            chk(rd_valid == 1'b0, "R5 single pulse", int'(rd_valid), 0);
        end
        while (!req_ready) @(negedge clk);
    endtask

    initial begin
        logic [15:0] rdat;
        int a0;
        // R1: reset state
        repeat (3) @(negedge clk);
        chk({dram_ras_n, dram_ucas_n, dram_lcas_n, dram_we_n, dram_oe_n} == 5'h1F &&
            !dram_dq_oe && !rd_valid, "R1 reset pins",
            int'({dram_ras_n, dram_ucas_n, dram_lcas_n, dram_we_n, dram_oe_n, dram_dq_oe, rd_valid}),
            int'(7'b1111100));
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready && dram_ras_n && !rd_valid, "R1 after reset",
            int'({req_ready, dram_ras_n, rd_valid}), 6);

        // table walk: R2..R7 via monitor, data and activations here
        for (int i = 0; i < NV; i++) begin
            a0 = act_cnt;
            issue(VEC[i].wr, VEC[i].addr, VEC[i].be, VEC[i].data, rdat);
            if (!VEC[i].wr)
                chk(rdat == VEC[i].data, "R5 read data", int'(rdat), int'(VEC[i].data));
            chk((act_cnt - a0) == int'(VEC[i].act), VEC[i].act ? "R7 row reopened" : "R6 page hit",
                act_cnt - a0, int'(VEC[i].act));
        end

        // R9: close request while row 0 is open
        @(negedge clk);
        close_req = 1'b1;
        #0.1;
        chk(req_ready == 1'b0, "R9 ready low on close", int'(req_ready), 0);
        for (int k = 0; k < 20 && !dram_ras_n; k++) @(negedge clk);
        chk(dram_ras_n == 1'b1, "R9 row closed", int'(dram_ras_n), 1);
        repeat (T_RP + 2) @(negedge clk);
        close_req = 1'b0;
        a0 = act_cnt;
        issue(1'b0, 20'h00000, 2'b11, 16'h0, rdat);
        chk(rdat == 16'hC3C3, "R9 read after close", int'(rdat), 16'hC3C3);
        chk(act_cnt - a0 == 1, "R9 reopen after close", act_cnt - a0, 1);

        // R10: long hit stream forces a close and reopen
        a0 = act_cnt;
        for (int k = 0; k < 18; k++) begin
            issue(1'b0, 20'h45600, 2'b11, 16'h0, rdat);
            if (k == 17) chk(rdat == 16'h77EF, "R10 data in stream", int'(rdat), 16'h77EF);
        end
        chk(act_cnt - a0 >= 2, "R10 forced reopen", act_cnt - a0, 2);

        repeat (5) @(negedge clk);
        finish_run();
    end
endmodule